// File: doc/BRIEF.md
# Programmable System Clock Divider Chain

The block turns four source clocks into the processor, bus, secondary bus and memory-interface clocks of a chip. One control register sets the path. The path has four stages, in this order:

1. A source selector picks one of the four sources.
2. A power-of-two prescaler divides the selected source. Its output is the processor clock.
3. A bus divider divides the processor clock by 1, 2, 3 or 4. Its output is the bus clock.
4. A final stage produces the secondary bus clock, either equal to the bus clock or at half its rate.

Every clock is modelled as a single-cycle tick on one fast reference clock. Each source input is a tick stream that marks the edges of that source.

Software writes the control register through a simple write port and can read it back at any time. A write-protect input freezes the register. The register refuses a write that holds an illegal setting and raises a sticky error flag instead. A divider stage takes a new setting only when its current output period ends. This means a setting change never produces a shortened period.

Top module: `clkdiv_chain`

## Requirements
- R1: After reset the register reads 0x00000001. With that value the main source (code 1) is selected, and the prescaler, bus and secondary stages all divide by 1. The error flag reads 0.
- R2: A write while `wp_en` is 1 leaves the register and the error flag unchanged. `rd_data` always shows the current register value, whatever the value of `wp_en`.
- R3: Only bits 24, 12, 9:8, 6:4 and 1:0 are stored. Every other bit reads as 0, whatever was written to it.
- R4: Bits 1:0 pick the source that feeds the prescaler: 0 slow, 1 main, 2 first PLL, 3 second PLL.
- R5: Bits 6:4 hold a code k from 0 to 6. The processor clock then gives one tick for every 2^k selected-source ticks.
- R6: An unprotected write is rejected if its bits 6:4 equal 7, or if its bits 9:8 equal 3 while bit 12 is 0. A rejected write leaves the register unchanged and sets `cfg_err`. Only reset clears `cfg_err`.
- R7: Bits 9:8 set how many processor ticks make one bus tick: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 3. Each bus tick therefore closes an exact window of that many processor ticks, including the divide-by-3 case.
- R8: `mem_valid` is 0 while the active bus divisor is 1 and is 1 otherwise. `mem_tick` equals `bus_tick` when `mem_valid` is 1 and stays 0 when it is 0.
- R9: When bit 24 is 0, `sub_tick` equals `bus_tick`. When bit 24 is 1, `sub_tick` gives one tick for every two bus ticks.
- R10: A stage adopts a new divisor only on the input tick that ends its current output period. The output period running at the time of the write therefore completes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow source tick |
| main_tick | input | 1 | Main source tick |
| plla_tick | input | 1 | First PLL source tick |
| upll_tick | input | 1 | Second PLL source tick |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| wp_en | input | 1 | Write protect, 1 blocks writes |
| rd_data | output | 32 | Current register value |
| cfg_err | output | 1 | Sticky flag for a rejected write |
| cpu_tick | output | 1 | Processor clock tick |
| bus_tick | output | 1 | Bus clock tick |
| sub_tick | output | 1 | Secondary bus clock tick |
| mem_tick | output | 1 | Memory-interface clock tick |
| mem_valid | output | 1 | Memory-interface clock available |

## Verification
The four source tick streams toggle at random and independently of one another. Only the selected stream can therefore explain the processor ticks, which makes a wrong source decode visible. Random register writes sweep every prescaler code and every bus divider code, with the secondary halving both on and off. Each setting runs long enough for whole periods to complete. The writes land at arbitrary phases of the running periods, which separates an adoption at the period boundary from an immediate one. Directed writes cover four cases: a write while protected, a reserved prescaler code, divide-by-3 without the halving bit, and a write with all unused bits set. These cases separate rejection, protection and masking from one another.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned DIV_W = 7;
  localparam logic [REG_W-1:0] CTRL_MASK  = 32'h0100_1373;
  localparam logic [REG_W-1:0] CTRL_RESET = 32'h0000_0001;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLLA = 2'd2,
    SRC_UPLL = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic       half_sub;
    logic       pll_half;
    logic [1:0] bus_code;
    logic [2:0] pre_code;
    src_sel_e   src;
  } ctrl_fields_t;

  function automatic ctrl_fields_t unpack_ctrl(input logic [REG_W-1:0] r);
    ctrl_fields_t f;
    f.half_sub = r[24];
    f.pll_half = r[12];
    f.bus_code = r[9:8];
    f.pre_code = r[6:4];
    f.src      = src_sel_e'(r[1:0]);
    return f;
  endfunction

  function automatic logic [DIV_W-1:0] bus_divisor(input logic [1:0] code);
    case (code)
      2'd0:    return DIV_W'(1);
      2'd1:    return DIV_W'(2);
      2'd2:    return DIV_W'(4);
      default: return DIV_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wp_en,
  output logic [REG_W-1:0] ctrl,
  output logic             err
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             err_q, err_d;
  logic             wr_ok, wr_bad;

  always_comb begin
    wr_ok  = wr_en && !wp_en;
    wr_bad = (wr_data[6:4] == 3'd7) || ((wr_data[9:8] == 2'd3) && !wr_data[12]);
    ctrl_d = ctrl_q;
    err_d  = err_q;
    if (wr_ok) begin
      if (wr_bad) err_d  = 1'b1;
      else        ctrl_d = wr_data & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign ctrl = ctrl_q;
  assign err  = err_q;

  assert_wp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp_en) |=> ($stable(ctrl_q) && $stable(err_q)));
  assert_legal_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6:4] != 3'd7) && (ctrl_q[9:8] != 2'd3 || ctrl_q[12]));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tick,
  input  logic [DIV_W-1:0] new_div,
  output logic             out_tick,
  output logic [DIV_W-1:0] cur_div
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == div_q - DIV_W'(1));
    cnt_d = cnt_q;
    div_d = div_q;
    if (in_tick) begin
      if (wrap) begin
        cnt_d = '0;
        div_d = new_div;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= DIV_W'(1);
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign out_tick = in_tick && wrap;
  assign cur_div  = div_q;

  assert_div_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_tick |=> $stable(div_q));
  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q);
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        main_tick,
  input  logic        plla_tick,
  input  logic        upll_tick,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        wp_en,
  output logic [31:0] rd_data,
  output logic        cfg_err,
  output logic        cpu_tick,
  output logic        bus_tick,
  output logic        sub_tick,
  output logic        mem_tick,
  output logic        mem_valid
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [REG_W-1:0] ctrl;
  ctrl_fields_t     f;
  logic             sel_tick;
  logic [DIV_W-1:0] pre_div, bus_div, sub_div;
  logic [DIV_W-1:0] pre_cur, bus_cur, sub_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  clkdiv_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .wp_en(wp_en), .ctrl(ctrl), .err(cfg_err)
  );

  always_comb begin
    f = unpack_ctrl(ctrl);
    case (f.src)
      SRC_SLOW: sel_tick = slow_tick;
      SRC_MAIN: sel_tick = main_tick;
      SRC_PLLA: sel_tick = plla_tick;
      default:  sel_tick = upll_tick;
    endcase
    pre_div = DIV_W'(1) << f.pre_code;
    bus_div = bus_divisor(f.bus_code);
    sub_div = f.half_sub ? DIV_W'(2) : DIV_W'(1);
  end

  clkdiv_stage u_pre (
    .clk(clk), .rst_n(rst_int_n), .in_tick(sel_tick), .new_div(pre_div),
    .out_tick(cpu_tick), .cur_div(pre_cur)
  );
  clkdiv_stage u_bus (
    .clk(clk), .rst_n(rst_int_n), .in_tick(cpu_tick), .new_div(bus_div),
    .out_tick(bus_tick), .cur_div(bus_cur)
  );
  clkdiv_stage u_sub (
    .clk(clk), .rst_n(rst_int_n), .in_tick(bus_tick), .new_div(sub_div),
    .out_tick(sub_tick), .cur_div(sub_cur)
  );

  assign mem_valid = (bus_cur != DIV_W'(1));
  assign mem_tick  = bus_tick && mem_valid;
  assign rd_data   = ctrl;

  assert_pre_div_legal_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(pre_cur) && (pre_cur != '0));
  assert_sub_div_range_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sub_cur == DIV_W'(1)) || (sub_cur == DIV_W'(2)));
  assert_mem_follows_bus_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_tick |-> (bus_tick && bus_cur != DIV_W'(1)));
endmodule

// File: tb/clkdiv_chain_bench.sv
module clkdiv_chain_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 0, main_tick = 0, plla_tick = 0, upll_tick = 0;
  logic        wr_en = 0, wp_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cfg_err, cpu_tick, bus_tick, sub_tick, mem_tick, mem_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural reference state
  int unsigned m_reg;
  bit          m_err;
  int          m_cnt[3];
  int          m_div[3];

  always #5 clk = ~clk;

  clkdiv_chain u_clkdiv_chain (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .main_tick(main_tick),
    .plla_tick(plla_tick), .upll_tick(upll_tick), .wr_en(wr_en), .wr_data(wr_data),
    .wp_en(wp_en), .rd_data(rd_data), .cfg_err(cfg_err), .cpu_tick(cpu_tick),
    .bus_tick(bus_tick), .sub_tick(sub_tick), .mem_tick(mem_tick), .mem_valid(mem_valid)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // R10: each modelled stage takes its new divisor only when its period closes
  function automatic bit stage_step(input int s, input bit in_t, input int nd);
    bit o;
    o = in_t && (m_cnt[s] == m_div[s] - 1);
    if (in_t) begin
      if (o) begin m_cnt[s] = 0; m_div[s] = nd; end
      else m_cnt[s]++;
    end
    return o;
  endfunction

  task automatic step(input bit wr, input logic [31:0] d, input bit wp);
    bit [3:0] src;
    bit sel, e_cpu, e_bus, e_sub, e_memv, e_mem;
    int pd, bd, sd;
    @(negedge clk);
    src = 4'($urandom);
    {upll_tick, plla_tick, main_tick, slow_tick} = src;
    wr_en = wr; wr_data = d; wp_en = wp;
    #1;
    check("R2", "rd_data", rd_data, m_reg);
    check("R6", "cfg_err", cfg_err, m_err);
    sel = src[m_reg[1:0]];
    pd  = 1 << ((m_reg >> 4) & 7);
    case ((m_reg >> 8) & 3)
      0: bd = 1; 1: bd = 2; 2: bd = 4; default: bd = 3;
    endcase
    sd = m_reg[24] ? 2 : 1;
    e_memv = (m_div[1] != 1);
    e_cpu = stage_step(0, sel, pd);
    e_bus = stage_step(1, e_cpu, bd);
    e_sub = stage_step(2, e_bus, sd);
    e_mem = e_bus && e_memv;
    check("R4 R5", "cpu_tick", cpu_tick, e_cpu);
    check("R7", "bus_tick", bus_tick, e_bus);
    check("R9", "sub_tick", sub_tick, e_sub);
    check("R8", "mem_valid", mem_valid, e_memv);
    check("R8", "mem_tick", mem_tick, e_mem);
    if (wr && !wp) begin
      if (d[6:4] == 3'd7 || (d[9:8] == 2'd3 && !d[12])) m_err = 1;
      else m_reg = d & 32'h0100_1373;
    end
  endtask

  function automatic logic [31:0] rand_cfg();
    logic [31:0] v;
    v = $urandom;
    if ($urandom_range(0, 9) != 0) begin
      if (v[6:4] == 3'd7) v[6:4] = 3'd6;
      if (v[9:8] == 2'd3) v[12] = 1'b1;
    end
    return v;
  endfunction

  initial begin
    m_reg = 32'h1; m_err = 0;
    for (int s = 0; s < 3; s++) begin m_cnt[s] = 0; m_div[s] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset rd_data", rd_data, 32'h1);
    check("R1", "reset cfg_err", cfg_err, 0);
    check("R1", "reset mem_valid", mem_valid, 0);
    // R1: main source passes straight through
    repeat (50) step(0, '0, 0);
    // R3: unused bits set, legal fields
    step(1, 32'hFEFF_EDBE, 0);
    step(0, '0, 0);
    check("R3", "masked readback", rd_data, 32'h0000_0132);
    // R2: protected illegal write ignored, no error
    step(1, 32'h0000_0070, 1);
    step(0, '0, 0);
    check("R2", "protected write", rd_data, 32'h0000_0132);
    check("R2", "protected err", cfg_err, 0);
    repeat (300) step(0, '0, 0);
    // R6: divide-by-3 without halving bit rejected
    step(1, 32'h0000_0300, 0);
    step(0, '0, 0);
    check("R6", "rejected write kept", rd_data, 32'h0000_0132);
    check("R6", "error raised", cfg_err, 1);
    // R7: legal divide-by-3 on main source
    step(1, 32'h0000_1301, 0);
    repeat (400) step(0, '0, 0);
    // random sweep of every field and phase
    for (int n = 0; n < 150; n++) begin
      step(1, rand_cfg(), ($urandom_range(0, 5) == 0));
      repeat ($urandom_range(100, 900)) step(0, '0, 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule